// File: doc/BRIEF.md
# Path-History Table Index Generator

This block sits in front of the weight memories of a scaled perceptron-style branch predictor. It holds two histories. The first is a global history of branch outcomes. The second is a path history made of the lowest address bit of each recent branch. From these and the program counter of the branch being predicted, it forms one row index for each of the sixteen correlating weight tables and one index for the bias table. It also supplies a 128-bit expanded outcome history for the dot product.

Each history exists twice. A speculative copy advances when a prediction is accepted, using the predicted direction and bit 0 of the PC. A committed copy advances when a branch resolves, using the real outcome and address bit. When a resolve reports a misprediction, the committed copy is advanced by that branch and the result is loaded into the speculative copy in the same cycle.

Predictions enter on a valid/ready channel and leave on a registered valid/ready channel. A result stays on the output, unchanged, until the consumer takes it. A new prediction is accepted only when the output register is free or is being drained in that cycle. No prediction is accepted while a mispredicting resolve is present. Resolves are plain strobes and are never refused.

Top module: `ph_index_gen`

## Requirements
- R1: After reset, out_valid is 0, pred_ready is 1, and both copies of both histories are all zeros. The first prediction therefore returns an expanded history of zero, and each index field equals its PC bits alone.
- R2: A prediction is accepted when pred_valid and pred_ready are both 1. Its results appear with out_valid = 1 on the next cycle. While out_valid = 1 and out_ready = 0, out_valid and all output data hold steady.
- R3: pred_ready = 1 exactly when (out_valid = 0 or out_ready = 1) and no mispredicting resolve (res_valid = 1 with res_mispred = 1) is present in the same cycle.
- R4: out_idx holds 16 fields of 9 bits each; field k sits at out_idx[9k+8:9k]. The path vector is numbered with bit 0 as the newest entry. Let slice k be path bits [8k+7:8k], zero-extended to 9 bits. Field 0 is slice 0 XOR pc[8:0]. For k ≥ 1, field k is slice k XOR pc[7:0], and bit 8 of the field is 0.
- R5: out_bias_idx equals pc[10:0] of the accepted prediction.
- R6: out_hist bit i equals outcome-history bit (i mod 40), with history bit 0 as the newest entry. The value is taken from the speculative history as it stood before the accepted prediction updated it.
- R7: An accepted prediction shifts pred_dir into bit 0 of the speculative outcome history and pred_pc[0] into bit 0 of the speculative path vector.
- R8: A resolve with res_valid = 1 shifts res_taken into the committed outcome history and res_addr_bit into the committed path vector. Without res_mispred, it leaves the speculative copies untouched.
- R9: A resolve with res_mispred = 1 loads both speculative copies from the committed copies, after this resolve's bits have been shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request present |
| pred_ready | output | 1 | Prediction request can be accepted |
| pred_pc | input | 32 | Branch PC of the request |
| pred_dir | input | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | Resolve strobe |
| res_taken | input | 1 | Resolved outcome, 1 = taken |
| res_addr_bit | input | 1 | Low address bit of the resolved branch |
| res_mispred | input | 1 | Resolved branch was mispredicted |
| out_valid | output | 1 | Index result present |
| out_ready | input | 1 | Consumer takes the result |
| out_idx | output | 144 | Sixteen 9-bit correlating-table indices |
| out_bias_idx | output | 11 | Bias-table index |
| out_hist | output | 128 | Expanded outcome history |

## Verification
The assertions assume the producer holds pred_valid and pred_pc only while it is handshaking. They also assume resolves arrive as single-cycle strobes whose mispredict flag has meaning only when res_valid is high. The random stimulus drives fresh values at every falling edge. It sets the mispredict flag independently of res_valid, so the flag also appears alone and must then be ignored. It throttles out_ready so that stalls and drains occur together with predictions and mispredicting resolves, including the cycle where a restore blocks a waiting prediction.

// File: rtl/ph_pkg.sv
package ph_pkg;
  localparam int unsigned PC_W_DEF    = 32;
  localparam int unsigned HIST_W_DEF  = 40;
  localparam int unsigned PATH_W_DEF  = 128;
  localparam int unsigned EXP_W_DEF   = 128;
  localparam int unsigned NT_DEF      = 16;
  localparam int unsigned SLICE_DEF   = 8;
  localparam int unsigned IDX0_W_DEF  = 9;
  localparam int unsigned IDX_W_DEF   = 8;
  localparam int unsigned BIAS_W_DEF  = 11;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ph_shift_pair.sv
module ph_shift_pair #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spec_push,
  input  logic         spec_bit,
  input  logic         com_push,
  input  logic         com_bit,
  input  logic         restore,
  output logic [W-1:0] spec_q,
  output logic [W-1:0] com_q
);
  logic [W-1:0] com_next;
  logic [W-1:0] spec_next;

  assign com_next  = {com_q[W-2:0], com_bit};
  assign spec_next = {spec_q[W-2:0], spec_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      com_q <= '0;
    end else if (com_push) begin
      com_q <= com_next;
    end
  end

  // restore wins over a speculative push; it carries the resolving branch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_q <= '0;
    end else if (restore) begin
      spec_q <= com_next;
    end else if (spec_push) begin
      spec_q <= spec_next;
    end
  end
endmodule

// File: rtl/ph_hist_expand.sv
module ph_hist_expand #(
  parameter int unsigned HW = 40,
  parameter int unsigned EW = 128
) (
  input  logic [HW-1:0] hist_i,
  output logic [EW-1:0] exp_o
);
  for (genvar i = 0; i < EW; i++) begin : g_bit
    localparam int unsigned SRC = i % HW;
    assign exp_o[i] = hist_i[SRC];
  end
endmodule

// File: rtl/ph_index_hash.sv
module ph_index_hash #(
  parameter int unsigned PATH_W  = 128,
  parameter int unsigned NT      = 16,
  parameter int unsigned SLICE   = 8,
  parameter int unsigned IDX0_W  = 9,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned FIELD_W = 9
) (
  input  logic [PATH_W-1:0]     path_i,
  input  logic [FIELD_W-1:0]    pc_i,
  output logic [NT*FIELD_W-1:0] idx_o
);
  for (genvar k = 0; k < NT; k++) begin : g_tbl
    localparam int unsigned TW = (k == 0) ? IDX0_W : IDX_W;
    localparam logic [FIELD_W-1:0] MASK = FIELD_W'((64'd1 << TW) - 64'd1);
    logic [SLICE-1:0]   slice;
    logic [FIELD_W-1:0] mix;
    assign slice = path_i[SLICE*k +: SLICE];
    assign mix   = FIELD_W'(slice) ^ pc_i;
    assign idx_o[FIELD_W*k +: FIELD_W] = mix & MASK;
  end
endmodule

// File: rtl/ph_index_gen.sv
module ph_index_gen
  import ph_pkg::*;
#(
  parameter int unsigned PC_W   = PC_W_DEF,
  parameter int unsigned HIST_W = HIST_W_DEF,
  parameter int unsigned PATH_W = PATH_W_DEF,
  parameter int unsigned EXP_W  = EXP_W_DEF,
  parameter int unsigned NT     = NT_DEF,
  parameter int unsigned SLICE  = SLICE_DEF,
  parameter int unsigned IDX0_W = IDX0_W_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned BIAS_W = BIAS_W_DEF,
  localparam int unsigned FIELD_W = max_u(IDX0_W, IDX_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pred_valid,
  output logic                  pred_ready,
  input  logic [PC_W-1:0]       pred_pc,
  input  logic                  pred_dir,
  input  logic                  res_valid,
  input  logic                  res_taken,
  input  logic                  res_addr_bit,
  input  logic                  res_mispred,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NT*FIELD_W-1:0] out_idx,
  output logic [BIAS_W-1:0]     out_bias_idx,
  output logic [EXP_W-1:0]      out_hist
);
  logic                  accept;
  logic                  restore;
  logic [HIST_W-1:0]     hist_spec, hist_com;
  logic [PATH_W-1:0]     path_spec, path_com;
  logic [NT*FIELD_W-1:0] idx_c;
  logic [EXP_W-1:0]      hist_exp_c;
  logic                  unused_bits;

  assign unused_bits = ^{hist_com, path_com, pred_pc[PC_W-1:BIAS_W]};

  assign restore    = res_valid & res_mispred;
  assign pred_ready = (~out_valid | out_ready) & ~restore;
  assign accept     = pred_valid & pred_ready;

  ph_shift_pair #(.W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .spec_push(accept), .spec_bit(pred_dir),
    .com_push(res_valid), .com_bit(res_taken),
    .restore(restore),
    .spec_q(hist_spec), .com_q(hist_com)
  );

  ph_shift_pair #(.W(PATH_W)) u_path (
    .clk(clk), .rst_n(rst_n),
    .spec_push(accept), .spec_bit(pred_pc[0]),
    .com_push(res_valid), .com_bit(res_addr_bit),
    .restore(restore),
    .spec_q(path_spec), .com_q(path_com)
  );

  ph_index_hash #(
    .PATH_W(PATH_W), .NT(NT), .SLICE(SLICE),
    .IDX0_W(IDX0_W), .IDX_W(IDX_W), .FIELD_W(FIELD_W)
  ) u_hash (
    .path_i(path_spec),
    .pc_i(pred_pc[FIELD_W-1:0]),
    .idx_o(idx_c)
  );

  ph_hist_expand #(.HW(HIST_W), .EW(EXP_W)) u_exp (
    .hist_i(hist_spec),
    .exp_o(hist_exp_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_idx      <= '0;
      out_bias_idx <= '0;
      out_hist     <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_idx      <= idx_c;
      out_bias_idx <= pred_pc[BIAS_W-1:0];
      out_hist     <= hist_exp_c;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/ph_index_gen_chk.sv
module ph_index_gen_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned HIST_W  = 40,
  parameter int unsigned EXP_W   = 128,
  parameter int unsigned NT      = 16,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned BIAS_W  = 11,
  parameter int unsigned FIELD_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pred_valid,
  input logic                  pred_ready,
  input logic [PC_W-1:0]       pred_pc,
  input logic                  res_valid,
  input logic                  res_mispred,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [NT*FIELD_W-1:0] out_idx,
  input logic [BIAS_W-1:0]     out_bias_idx,
  input logic [EXP_W-1:0]      out_hist
);
  logic [NT-1:0] upper_nz;
  assign upper_nz[0] = 1'b0;
  for (genvar k = 1; k < NT; k++) begin : g_up
    if (FIELD_W > IDX_W) begin : g_has
      assign upper_nz[k] = |out_idx[FIELD_W*k+IDX_W +: FIELD_W-IDX_W];
    end else begin : g_none
      assign upper_nz[k] = 1'b0;
    end
  end

  AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_ready |=> out_valid); // R2
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_bias_idx) && $stable(out_hist)); // R2
  AST_NO_ACCEPT_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_mispred |-> !pred_ready); // R3
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(res_valid && res_mispred) |-> pred_ready); // R3
  AST_UPPER_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> upper_nz == '0); // R4
  AST_BIAS_FOLLOWS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_ready |=> out_bias_idx == $past(pred_pc[BIAS_W-1:0])); // R5
  AST_HIST_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_hist[2*HIST_W-1:HIST_W] == out_hist[HIST_W-1:0]); // R6
endmodule

bind ph_index_gen ph_index_gen_chk #(
  .PC_W(PC_W), .HIST_W(HIST_W), .EXP_W(EXP_W), .NT(NT),
  .IDX_W(IDX_W), .BIAS_W(BIAS_W), .FIELD_W(FIELD_W)
) u_chk (.*);

// File: tb/tb_ph_index_gen.sv
module tb_ph_index_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 0, pred_dir = 0, res_valid = 0, res_taken = 0;
  logic res_addr_bit = 0, res_mispred = 0, out_ready = 0;
  logic [31:0] pred_pc = '0;
  logic pred_ready, out_valid;
  logic [143:0] out_idx;
  logic [10:0] out_bias_idx;
  logic [127:0] out_hist;

  int n_run = 0, n_fail = 0;

  logic [39:0] m_sh, m_ch;
  logic [127:0] m_sp, m_cp;
  logic m_v;
  logic [143:0] m_idx;
  logic [10:0] m_bias;
  logic [127:0] m_hist;

  always #4 clk = ~clk;

  ph_index_gen dut (.*);

  function automatic logic [143:0] f_idx(logic [127:0] p, logic [31:0] pc);
    logic [143:0] r;
    r = '0;
    for (int k = 0; k < 16; k++) begin
      logic [8:0] s;
      s = {1'b0, p[8*k +: 8]} ^ pc[8:0];
      if (k != 0) s[8] = 1'b0;
      r[9*k +: 9] = s;
    end
    return r;
  endfunction

  function automatic logic [127:0] f_exp(logic [39:0] h);
    logic [127:0] r;
    for (int i = 0; i < 128; i++) r[i] = h[i % 40];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit pv, input logic [31:0] pc, input bit dir,
                      input bit rv, input bit tk, input bit ab, input bit mp, input bit ordy);
    bit exp_rdy, acc;
    chk(out_valid == m_v, "R2 out_valid", 144'(out_valid), 144'(m_v));
    if (m_v) begin
      chk(out_idx == m_idx, "R4 R7 R8 R9 out_idx", out_idx, m_idx);
      chk(out_bias_idx == m_bias, "R5 bias", 144'(out_bias_idx), 144'(m_bias));
      chk(out_hist == m_hist, "R6 R7 R9 out_hist", 144'(out_hist), 144'(m_hist));
    end
    pred_valid = pv; pred_pc = pc; pred_dir = dir;
    res_valid = rv; res_taken = tk; res_addr_bit = ab; res_mispred = mp;
    out_ready = ordy;
    #1;
    exp_rdy = (!m_v || ordy) && !(rv && mp);
    chk(pred_ready == exp_rdy, "R3 pred_ready", 144'(pred_ready), 144'(exp_rdy));
    acc = pv && exp_rdy;
    if (acc) begin
      m_idx = f_idx(m_sp, pc); m_bias = pc[10:0]; m_hist = f_exp(m_sh); m_v = 1'b1;
    end else if (ordy) m_v = 1'b0;
    if (rv) begin
      m_ch = {m_ch[38:0], tk}; m_cp = {m_cp[126:0], ab};
    end
    if (rv && mp) begin
      m_sh = m_ch; m_sp = m_cp;
    end else if (acc) begin
      m_sh = {m_sh[38:0], dir}; m_sp = {m_sp[126:0], pc[0]};
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_sh = '0; m_ch = '0; m_sp = '0; m_cp = '0; m_v = 0;
    m_idx = '0; m_bias = '0; m_hist = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", 144'(out_valid), 144'd0);
    chk(pred_ready == 1'b1, "R1 pred_ready after reset", 144'(pred_ready), 144'd1);
    @(negedge clk);
    // R1: first prediction sees zero histories
    step(1, 32'h0000_05A5, 1, 0, 0, 0, 0, 1);
    chk(out_hist == '0, "R1 first hist zero", 144'(out_hist), 144'd0);
    chk(out_idx == f_idx('0, 32'h5A5), "R1 first idx", out_idx, f_idx('0, 32'h5A5));
    // R7: build speculative history
    for (int i = 0; i < 20; i++) step(1, 32'h100 + i, i[0], 0, 0, 0, 0, 1);
    // R2: stall with a waiting prediction
    step(1, 32'h0000_7FF3, 1, 0, 0, 0, 0, 0);
    step(1, 32'h0000_0123, 0, 0, 0, 0, 0, 0);
    step(1, 32'h0000_0456, 0, 0, 0, 0, 0, 0);
    // R8: resolves without mispredict leave speculative copies untouched
    step(0, 0, 0, 1, 1, 1, 0, 1);
    step(0, 0, 0, 1, 1, 0, 0, 1);
    step(1, 32'h0000_0FFF, 1, 0, 0, 0, 0, 1);
    // R9 R3: mispredict blocks a waiting prediction and restores
    step(1, 32'h0000_0333, 1, 1, 0, 1, 1, 1);
    step(1, 32'h0000_0333, 1, 0, 0, 0, 0, 1);
    // mispredict flag without res_valid has no effect (R8)
    step(1, 32'h0000_0777, 0, 0, 0, 0, 1, 1);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      step($urandom_range(0, 3) != 0, $urandom, $urandom_range(0, 1),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule